// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block sits between a set of level-sensitive interrupt request lines and a CPU core. There are 32 lines by default, and the count is a parameter. The block keeps an enable bit, a pending bit and a 3-bit priority for each line. It also has one non-maskable request. Every cycle it decides whether a request should be offered to the CPU. If so, it gives the winning number and the vector address the CPU should fetch from.

The CPU answers with an accept strobe when it starts a handler and a return strobe when the handler finishes. Inside the block, a stack records the priority of every handler that has been entered and not yet returned. While a handler runs, a new request may interrupt it only if the preemption part of its priority is strictly more urgent.

The split between preemption bits and subpriority bits is chosen at run time by a grouping field. A global mask and a priority threshold narrow the set of lines that can be taken further. The non-maskable request ignores both of them.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A line is only offered when its enable bit is set. Setting the enable of a pending line makes it offered in the next cycle. Clearing the enable withdraws the offer in the next cycle.
- R2: While the global mask input is high, no maskable line is offered, and the enable bits reported on `en_o` keep their values.
- R3: A pending non-maskable request is offered whatever the global mask and the threshold are, and it wins over every line. It is reported with number N_LINES and `take_nmi_o` high. While its handler runs, no line is offered.
- R4: A software set strobe makes a line's pending bit read 1 on `pend_o` in the next cycle. A software clear strobe with the source low makes it read 0 in the next cycle.
- R5: Accepting a line clears its pending bit in the next cycle if the source is low. If the source is still high, the bit stays 1.
- R6: Among offerable lines, the one with the numerically smallest 3-bit priority wins. 0 is the most urgent and 7 the least.
- R7: With threshold T not 0, a line of priority p is offered only if p < T. With T = 0 the threshold blocks nothing.
- R8: With grouping M (0..3), the preemption part of a priority is p >> M. While a handler of priority r runs, a line of priority p is offered only if (p >> M) < (r >> M).
- R9: A line whose preemption part equals that of the running handler is not offered. In the cycle after the return strobe it is offered, with no other input changed.
- R10: When offerable lines share the same full priority, the one with the lowest number wins.
- R11: The vector address is {base, 8'h00} + 4 × number. The base is `vtab_base_i`, which supplies address bits 31:8, so the table base is 256-byte aligned. The non-maskable request uses number N_LINES.
- R12: Each accepted line pushes its priority, and `run_prio_o` shows the top entry. A return pops it and restores the previous running priority. `run_valid_o` falls when the last handler returns. The stack never grows beyond the eight levels.
- R13: After reset, all enables, pending bits and priorities are 0, nothing is offered, and no handler is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | N_LINES | Level-sensitive request lines |
| nmi_i | input | 1 | Non-maskable request, level-sensitive |
| en_set_i | input | N_LINES | Enable set strobes (set wins over clear) |
| en_clr_i | input | N_LINES | Enable clear strobes |
| pend_set_i | input | N_LINES | Pending set strobes |
| pend_clr_i | input | N_LINES | Pending clear strobes |
| prio_we_i | input | 1 | Priority write strobe |
| prio_idx_i | input | IDW | Line whose priority is written |
| prio_val_i | input | 3 | Priority value to write |
| gmask_i | input | 1 | Global mask for maskable lines |
| prio_thresh_i | input | 3 | Priority threshold, 0 = off |
| group_m_i | input | 2 | Number of subpriority bits M |
| vtab_base_i | input | 24 | Vector table base, address bits 31:8 |
| accept_i | input | 1 | CPU takes the offered request |
| ret_i | input | 1 | CPU returns from the running handler |
| take_o | output | 1 | A request is offered |
| take_nmi_o | output | 1 | The offered request is the non-maskable one |
| take_id_o | output | IDW | Number of the offered request |
| take_vec_o | output | 32 | Vector address of the offered request |
| en_o | output | N_LINES | Enable bits |
| pend_o | output | N_LINES | Pending bits |
| run_valid_o | output | 1 | At least one line handler is running |
| run_prio_o | output | 3 | Priority of the innermost running line handler |
| nmi_active_o | output | 1 | The non-maskable handler is running |

## Verification
The bench uses eight lines and sweeps every pair of lines against every pair of priorities. This catches a selector that lets a higher number win a tie, or that compares only some of the priority bits.

The preemption test goes through every grouping value against every running and incoming priority, and then returns the handler. A block that compares full priorities instead of preemption parts would preempt where it must wait. A block that forgets to rearbitrate after a pop would leave the waiting line stranded.

The remaining tests cover three more mistakes:
- an off-by-one threshold, where p = T slips through;
- a pending bit that the accept strobe clears even though the source is still high;
- a nesting stack that restores the wrong entry on return.

// File: rtl/nic_pkg.sv
package nic_pkg;

  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned N_LEVELS = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;

  // Upper bits of a priority that take part in preemption.
  function automatic prio_t preempt_part(input prio_t p, input logic [1:0] m);
    return prio_t'(p >> m);
  endfunction

  // Threshold filter: zero disables it, otherwise strictly more urgent passes.
  function automatic logic passes_thresh(input prio_t p, input prio_t th);
    return (th == '0) || (p < th);
  endfunction

  // Table base occupies address bits 31:8; each slot is one 32-bit word.
  function automatic logic [31:0] vec_addr(input logic [23:0] base, input logic [7:0] num);
    return {base, 8'h00} + {22'd0, num, 2'b00};
  endfunction

endpackage

// File: rtl/nic_line_bank.sv
module nic_line_bank
  import nic_pkg::*;
#(
  parameter int unsigned N   = 32,
  parameter int unsigned IDW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    src_i,
  input  logic [N-1:0]    en_set_i,
  input  logic [N-1:0]    en_clr_i,
  input  logic [N-1:0]    pend_set_i,
  input  logic [N-1:0]    pend_clr_i,
  input  logic            prio_we_i,
  input  logic [IDW-1:0]  prio_idx_i,
  input  prio_t           prio_val_i,
  input  logic            ack_i,
  input  logic [IDW-1:0]  ack_idx_i,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    pend_o,
  output prio_t [N-1:0]   prio_o
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic  en_q;
    logic  pend_q;
    prio_t prio_q;
    logic  ack_here;
    logic  wr_here;

    assign ack_here = ack_i && (ack_idx_i == IDW'(i));
    assign wr_here  = prio_we_i && (prio_idx_i == IDW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        prio_q <= '0;
      end else begin
        if (en_set_i[i])      en_q <= 1'b1;
        else if (en_clr_i[i]) en_q <= 1'b0;
        // A live source or a set strobe re-arms the bit after any clear.
        pend_q <= src_i[i] | pend_set_i[i] | (pend_q & ~pend_clr_i[i] & ~ack_here);
        if (wr_here) prio_q <= prio_val_i;
      end
    end

    assign en_o[i]   = en_q;
    assign pend_o[i] = pend_q;
    assign prio_o[i] = prio_q;
  end

endmodule

// File: rtl/nic_select.sv
module nic_select
  import nic_pkg::*;
#(
  parameter int unsigned N   = 32,
  parameter int unsigned IDW = 6
) (
  input  logic [N-1:0]   en_i,
  input  logic [N-1:0]   pend_i,
  input  prio_t [N-1:0]  prio_i,
  input  logic           gmask_i,
  input  prio_t          thresh_i,
  input  logic [1:0]     group_m_i,
  input  logic           run_valid_i,
  input  prio_t          run_prio_i,
  input  logic           hold_i,
  output logic           found_o,
  output logic [IDW-1:0] win_idx_o,
  output prio_t          win_prio_o
);

  logic [N-1:0] elig;
  prio_t        run_part;

  assign run_part = preempt_part(run_prio_i, group_m_i);

  for (genvar i = 0; i < N; i++) begin : g_elig
    logic beats_running;
    assign beats_running = !run_valid_i || (preempt_part(prio_i[i], group_m_i) < run_part);
    assign elig[i] = en_i[i] && pend_i[i] && !gmask_i && !hold_i &&
                     passes_thresh(prio_i[i], thresh_i) && beats_running;
  end

  // Ascending scan with a strict compare: on equal priority the first line stays.
  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found_o || (prio_i[i] < win_prio_o))) begin
        found_o    = 1'b1;
        win_idx_o  = IDW'(i);
        win_prio_o = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/nic_active_stack.sv
module nic_active_stack
  import nic_pkg::*;
#(
  parameter int unsigned DEPTH = N_LEVELS,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  prio_t         push_prio_i,
  input  logic          pop_i,
  output logic          run_valid_o,
  output prio_t         run_prio_o,
  output logic [CW-1:0] depth_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  prio_t         slot_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] top_idx;
  logic [AW-1:0] wr_idx;

  assign top_idx = AW'(cnt_q - CW'(1));
  assign wr_idx  = AW'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int k = 0; k < int'(DEPTH); k++) slot_q[k] <= '0;
    end else if (pop_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end else if (push_i && (cnt_q != CW'(DEPTH))) begin
      slot_q[wr_idx] <= push_prio_i;
      cnt_q          <= cnt_q + CW'(1);
    end
  end

  assign run_valid_o = (cnt_q != '0);
  assign run_prio_o  = run_valid_o ? slot_q[top_idx] : '0;
  assign depth_o     = cnt_q;

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter  int unsigned N_LINES = 32,
  localparam int unsigned IDW     = $clog2(N_LINES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_src_i,
  input  logic               nmi_i,
  input  logic [N_LINES-1:0] en_set_i,
  input  logic [N_LINES-1:0] en_clr_i,
  input  logic [N_LINES-1:0] pend_set_i,
  input  logic [N_LINES-1:0] pend_clr_i,
  input  logic               prio_we_i,
  input  logic [IDW-1:0]     prio_idx_i,
  input  logic [2:0]         prio_val_i,
  input  logic               gmask_i,
  input  logic [2:0]         prio_thresh_i,
  input  logic [1:0]         group_m_i,
  input  logic [23:0]        vtab_base_i,
  input  logic               accept_i,
  input  logic               ret_i,
  output logic               take_o,
  output logic               take_nmi_o,
  output logic [IDW-1:0]     take_id_o,
  output logic [31:0]        take_vec_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] pend_o,
  output logic               run_valid_o,
  output logic [2:0]         run_prio_o,
  output logic               nmi_active_o
);

  localparam int unsigned SCW = $clog2(N_LEVELS + 1);

  // Named internal events, also observed by the checker.
  prio_t [N_LINES-1:0] prio_tab;
  logic                found;
  logic [IDW-1:0]      win_idx;
  prio_t               win_prio;
  logic                nmi_pend_q;
  logic                nmi_act_q;
  logic                nmi_take;
  logic                acc_ok;
  logic                acc_line;
  logic                acc_nmi;
  logic                stk_pop;
  logic [SCW-1:0]      stk_depth;

  nic_line_bank #(.N(N_LINES), .IDW(IDW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (irq_src_i),
    .en_set_i   (en_set_i),
    .en_clr_i   (en_clr_i),
    .pend_set_i (pend_set_i),
    .pend_clr_i (pend_clr_i),
    .prio_we_i  (prio_we_i),
    .prio_idx_i (prio_idx_i),
    .prio_val_i (prio_val_i),
    .ack_i      (acc_line),
    .ack_idx_i  (win_idx),
    .en_o       (en_o),
    .pend_o     (pend_o),
    .prio_o     (prio_tab)
  );

  nic_select #(.N(N_LINES), .IDW(IDW)) u_sel (
    .en_i        (en_o),
    .pend_i      (pend_o),
    .prio_i      (prio_tab),
    .gmask_i     (gmask_i),
    .thresh_i    (prio_thresh_i),
    .group_m_i   (group_m_i),
    .run_valid_i (run_valid_o),
    .run_prio_i  (run_prio_o),
    .hold_i      (nmi_act_q),
    .found_o     (found),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  nic_active_stack #(.DEPTH(N_LEVELS), .CW(SCW)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (acc_line),
    .push_prio_i (win_prio),
    .pop_i       (stk_pop),
    .run_valid_o (run_valid_o),
    .run_prio_o  (run_prio_o),
    .depth_o     (stk_depth)
  );

  assign nmi_take = nmi_pend_q && !nmi_act_q;
  assign acc_ok   = accept_i && !ret_i && take_o;
  assign acc_line = acc_ok && !nmi_take;
  assign acc_nmi  = acc_ok && nmi_take;
  // The NMI handler, when present, is always the innermost one.
  assign stk_pop  = ret_i && !nmi_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
    end else begin
      nmi_pend_q <= nmi_i | (nmi_pend_q & ~acc_nmi);
      if (ret_i && nmi_act_q) nmi_act_q <= 1'b0;
      else if (acc_nmi)       nmi_act_q <= 1'b1;
    end
  end

  assign take_o       = nmi_take || found;
  assign take_nmi_o   = nmi_take;
  assign take_id_o    = nmi_take ? IDW'(N_LINES) : win_idx;
  assign take_vec_o   = vec_addr(vtab_base_i, 8'(take_id_o));
  assign nmi_active_o = nmi_act_q;

endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
#(
  parameter int unsigned N   = 32,
  parameter int unsigned IDW = 6,
  parameter int unsigned SCW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           gmask_i,
  input prio_t          thresh_i,
  input logic [1:0]     group_m_i,
  input logic [N-1:0]   src_i,
  input logic [N-1:0]   pend_set_i,
  input logic [N-1:0]   en_i,
  input logic [N-1:0]   pend_i,
  input logic           take_i,
  input logic           take_nmi_i,
  input logic [IDW-1:0] take_id_i,
  input logic [31:0]    take_vec_i,
  input prio_t          win_prio_i,
  input logic           run_valid_i,
  input prio_t          run_prio_i,
  input logic           push_i,
  input logic [SCW-1:0] depth_i
);

  logic [N-1:0] id_hot;
  logic         line_take;

  assign id_hot    = N'(1) << take_id_i;
  assign line_take = take_i && !take_nmi_i;

  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_take |-> ((en_i & id_hot) != '0)); // R1

  AST_GMASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_i |-> !line_take); // R2

  AST_THRESH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_take && (thresh_i != '0)) |-> (win_prio_i < thresh_i)); // R7

  AST_PREEMPT_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_take && run_valid_i) |-> ((win_prio_i >> group_m_i) < (run_prio_i >> group_m_i))); // R8

  AST_ACCEPT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && (((src_i | pend_set_i) & id_hot) == '0)) |=> ((pend_i & $past(id_hot)) == '0)); // R5

  AST_VEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (take_vec_i[1:0] == 2'b00)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (depth_i < SCW'(N_LEVELS))); // R12

endmodule

bind nested_irq_ctrl nic_checker #(.N(N_LINES), .IDW(IDW), .SCW(SCW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gmask_i     (gmask_i),
  .thresh_i    (prio_thresh_i),
  .group_m_i   (group_m_i),
  .src_i       (irq_src_i),
  .pend_set_i  (pend_set_i),
  .en_i        (en_o),
  .pend_i      (pend_o),
  .take_i      (take_o),
  .take_nmi_i  (take_nmi_o),
  .take_id_i   (take_id_o),
  .take_vec_i  (take_vec_o),
  .win_prio_i  (win_prio),
  .run_valid_i (run_valid_o),
  .run_prio_i  (run_prio_o),
  .push_i      (acc_line),
  .depth_i     (stk_depth)
);

// File: tb/nested_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb_top;

  localparam int N   = 8;
  localparam int IDW = 4;
  localparam logic [23:0] BASE = 24'h0ABCDE;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src = '0, en_set = '0, en_clr = '0, p_set = '0, p_clr = '0;
  logic           nmi = 1'b0, pwe = 1'b0, gmask = 1'b0, acc = 1'b0, ret = 1'b0;
  logic [IDW-1:0] pidx = '0;
  logic [2:0]     pval = '0, thresh = '0;
  logic [1:0]     gm = '0;
  logic           take, take_nmi, run_valid, nmi_act;
  logic [IDW-1:0] take_id;
  logic [31:0]    take_vec;
  logic [N-1:0]   en, pend;
  logic [2:0]     run_prio;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  nested_irq_ctrl #(.N_LINES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .nmi_i(nmi),
    .en_set_i(en_set), .en_clr_i(en_clr), .pend_set_i(p_set), .pend_clr_i(p_clr),
    .prio_we_i(pwe), .prio_idx_i(pidx), .prio_val_i(pval), .gmask_i(gmask),
    .prio_thresh_i(thresh), .group_m_i(gm), .vtab_base_i(BASE),
    .accept_i(acc), .ret_i(ret), .take_o(take), .take_nmi_o(take_nmi),
    .take_id_o(take_id), .take_vec_o(take_vec), .en_o(en), .pend_o(pend),
    .run_valid_o(run_valid), .run_prio_o(run_prio), .nmi_active_o(nmi_act));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_prio(input int idx, input int val);
    pwe = 1'b1; pidx = IDW'(idx); pval = 3'(val);
    step();
    pwe = 1'b0;
  endtask

  task automatic pend_line(input int idx);
    p_set = N'(1) << idx;
    step();
    p_set = '0;
  endtask

  task automatic unpend(input logic [N-1:0] m);
    p_clr = m;
    step();
    p_clr = '0;
  endtask

  task automatic do_accept();
    acc = 1'b1;
    step();
    acc = 1'b0;
  endtask

  task automatic do_return();
    ret = 1'b1;
    step();
    ret = 1'b0;
  endtask

  function automatic logic [31:0] exp_vec(input int num);
    return BASE * 256 + num * 4;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: state after reset
    check("R13 take", 32'(take), 0);
    check("R13 en", 32'(en), 0);
    check("R13 pend", 32'(pend), 0);
    check("R13 run", 32'(run_valid), 0);
    check("R13 nmi", 32'(nmi_act), 0);

    // R1 / R4: enable gating and software pending, per line
    for (int i = 0; i < N; i++) begin
      pend_line(i);
      check("R4 set", 32'(pend), 32'(1 << i));
      check("R1 off", 32'(take), 0);
      en_set = N'(1) << i; step(); en_set = '0;
      check("R1 on", 32'(take), 1);
      check("R1 id", 32'(take_id), 32'(i));
      en_clr = N'(1) << i; step(); en_clr = '0;
      check("R1 cleared", 32'(take), 0);
      unpend(N'(1) << i);
      check("R4 clr", 32'(pend), 0);
    end

    // R6 / R10 / R11: every pair of lines against every pair of priorities
    en_set = '1; step(); en_set = '0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        for (int pa = 0; pa < 8; pa++)
          for (int pb = 0; pb < 8; pb++) begin
            int w;
            set_prio(a, pa);
            set_prio(b, pb);
            p_set = (N'(1) << a) | (N'(1) << b); step(); p_set = '0;
            w = (pb < pa) ? b : a;
            if (pa == pb) check("R10 tie", 32'(take_id), 32'(w));
            else          check("R6 order", 32'(take_id), 32'(w));
            check("R11 vec", take_vec, exp_vec(w));
            unpend((N'(1) << a) | (N'(1) << b));
          end

    // R7: threshold sweep on line 0
    for (int p = 0; p < 8; p++)
      for (int th = 0; th < 8; th++) begin
        set_prio(0, p);
        thresh = 3'(th);
        pend_line(0);
        check("R7 thresh", 32'(take), 32'((th == 0) || (p < th)));
        unpend(N'(1));
      end
    thresh = '0;

    // R2 / R3: global mask and non-maskable request
    set_prio(3, 1);
    gmask = 1'b1;
    pend_line(3);
    check("R2 masked", 32'(take), 0);
    check("R2 enables kept", 32'(en), 32'({N{1'b1}}));
    thresh = 3'd1;
    nmi = 1'b1; step(); nmi = 1'b0;
    check("R3 nmi taken", 32'(take_nmi), 1);
    check("R3 nmi id", 32'(take_id), 32'(N));
    check("R11 nmi vec", take_vec, exp_vec(N));
    do_accept();
    check("R3 nmi active", 32'(nmi_act), 1);
    gmask = 1'b0; thresh = '0; step();
    check("R3 lines held", 32'(take), 0);
    do_return();
    check("R3 after nmi", 32'(take_id), 3);
    check("R3 after nmi take", 32'(take), 1);
    nmi = 1'b1; step(); nmi = 1'b0;
    check("R3 nmi wins", 32'(take_nmi), 1);
    do_accept();
    do_return();
    unpend(N'(1) << 3);
    check("R3 idle", 32'(take), 0);

    // R8 / R9 / R12: preemption under every grouping value
    for (int m = 0; m < 4; m++)
      for (int pr = 0; pr < 8; pr++)
        for (int pn = 0; pn < 8; pn++) begin
          int e;
          gm = 2'(m);
          set_prio(0, pr);
          set_prio(1, pn);
          pend_line(0);
          do_accept();
          check("R12 running", 32'(run_prio), 32'(pr));
          pend_line(1);
          e = ((pn / (1 << m)) < (pr / (1 << m))) ? 1 : 0;
          if ((pn / (1 << m)) == (pr / (1 << m))) check("R9 no preempt", 32'(take), 0);
          else                                    check("R8 preempt", 32'(take), 32'(e));
          do_return();
          check("R9 after return", 32'(take), 1);
          check("R9 after return id", 32'(take_id), 1);
          unpend(N'(2));
        end
    gm = '0;

    // R5: re-pend while the source stays high
    set_prio(2, 5);
    src = N'(1) << 2; step();
    check("R5 offered", 32'(take_id), 2);
    do_accept();
    check("R5 repend", 32'(pend[2]), 1);
    src = '0;
    do_return();
    check("R5 still offered", 32'(take), 1);
    do_accept();
    check("R5 cleared", 32'(pend[2]), 0);
    do_return();
    check("R5 idle", 32'(take), 0);

    // R12: four nested handlers, unwound one by one
    for (int k = 0; k < 4; k++) begin
      set_prio(k, 6 - 2 * k);
      pend_line(k);
      do_accept();
      check("R12 push", 32'(run_prio), 32'(6 - 2 * k));
    end
    set_prio(4, 0);
    pend_line(4);
    check("R8 equal blocked", 32'(take), 0);
    unpend(N'(1) << 4);
    for (int k = 3; k > 0; k--) begin
      do_return();
      check("R12 pop", 32'(run_prio), 32'(6 - 2 * (k - 1)));
    end
    do_return();
    check("R12 empty", 32'(run_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule